// File: doc/BRIEF.md
# Floppy Controller DMA Request Generator

This block raises the DMA request line that a floppy disk controller presents to a system DMA controller while a data-transfer command moves bytes between memory and the controller's data FIFO. It watches the DMA acknowledge and terminal count pins. It produces one FIFO read or write strobe for each acknowledged transfer. When terminal count is seen together with an acknowledge, it reports the end of the transfer to the command sequencer with a one-cycle done pulse.

Two handshake styles are supported, chosen by a configuration bit. In single-transfer mode the request is dropped after every acknowledge. It is raised again only after the acknowledge has gone away, and only while the FIFO can take part in another byte. In burst mode the request stays up across acknowledges until the last transfer.

Two interface personalities are also supported. In the first, the output-register DMA enable bit is ignored, the request and interrupt pins are always driven, and terminal count is active low. In the second, that enable bit gates both requests and pin drive, and terminal count is active high.

Top module: `fdc_dma_req`

## Requirements
- R1: `mode_nburst` = 1 selects single-transfer mode and `mode_nburst` = 0 selects burst mode; the two modes differ in whether `drq` survives an acknowledge.
- R2: In single-transfer mode, an acknowledge (`dack_n` low) sampled while `drq` is high makes `drq` low from the following clock edge.
- R3: In single-transfer mode, after an acknowledge is released, `drq` stays low for the first clock edge that sees `dack_n` high and rises no earlier than the edge after it.
- R4: In burst mode, `drq` stays high through acknowledges and their release until a transfer carries terminal count or the transfer is no longer permitted.
- R5: An acknowledged cycle sampled with active terminal count drops `drq` at the next edge and produces a one-clock `xfer_done` pulse. No further request is raised until `xfer_active` goes low.
- R6: `drq` is raised only while `xfer_active` = 1 and `spec_dma_en` = 1. If either is low, `drq` is low from the next edge.
- R7: With `persona_ps2` = 1, `dor_dma_en` has no effect, `drq_oe` and `int_oe` are 1, and terminal count is active when `tc_pin` = 0.
- R8: With `persona_ps2` = 0, `dor_dma_en` = 0 blocks requests and makes `drq_oe` and `int_oe` 0, and terminal count is active when `tc_pin` = 1.
- R9: Each acknowledge that starts while `drq` is high gives exactly one strobe, one cycle long, in the cycle after it is first sampled. The strobe is `fifo_rd_stb` when `dir_read` = 1 and `fifo_wr_stb` when `dir_read` = 0, and never both.
- R10: During and immediately after reset, `drq`, `fifo_rd_stb`, `fifo_wr_stb` and `xfer_done` are 0.
- R11: A request is raised only when the FIFO is ready for the direction: `fifo_has_data` = 1 for `dir_read` = 1, and `fifo_has_space` = 1 for `dir_read` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_nburst | input | 1 | Configuration bit: 1 single-transfer, 0 burst |
| persona_ps2 | input | 1 | Interface personality: 1 PS/2 rules, 0 Model 30 rules |
| dor_dma_en | input | 1 | DMA enable bit of the digital output register |
| spec_dma_en | input | 1 | DMA mode selected by the Specify command |
| xfer_active | input | 1 | Data-transfer command is in its execution phase |
| dir_read | input | 1 | 1 when the host reads the FIFO, 0 when it writes |
| fifo_has_data | input | 1 | FIFO holds at least one byte for the host |
| fifo_has_space | input | 1 | FIFO can accept at least one byte |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_pin | input | 1 | Raw terminal count pin |
| drq | output | 1 | DMA request |
| drq_oe | output | 1 | Output enable for the request pin |
| int_oe | output | 1 | Output enable for the interrupt pin |
| fifo_rd_stb | output | 1 | One-cycle FIFO read strobe |
| fifo_wr_stb | output | 1 | One-cycle FIFO write strobe |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Seeded random transfers vary the mode, personality, enable bits, direction and number of acknowledges before terminal count. Comparing the two modes on the same acknowledge train shows whether the request falls or is held. Comparing personalities with the enable bit clear, and with both terminal count levels, separates the gating and polarity rules. Directed cases starve the FIFO in each direction and withdraw the Specify enable, which shows that readiness and permission are checked before every request.

// File: rtl/fdc_dma_pkg.sv
package fdc_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_HOLD = 2'd2,
      ST_DONE = 2'd3
   } dma_st_e;

   localparam int unsigned MAX_SYNC = 3;

   function automatic logic tc_decode(input logic raw, input logic active_low);
      return active_low ? ~raw : raw;
   endfunction

endpackage

// File: rtl/fdc_dma_insync.sv
module fdc_dma_insync #(
   parameter int unsigned         STAGES = 0,
   parameter int unsigned         W      = 2,
   parameter logic [W-1:0]        RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_flops
         logic [W-1:0] chain [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST;
               else if (s == 0) chain[s] <= d;
               else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fdc_dma_qual.sv
module fdc_dma_qual #(
   parameter bit PS2_TC_LOW = 1'b1
) (
   input  logic persona_ps2,
   input  logic dor_dma_en,
   input  logic spec_dma_en,
   input  logic dir_read,
   input  logic fifo_has_data,
   input  logic fifo_has_space,
   input  logic dack_n_s,
   input  logic tc_s,
   output logic dma_ok,
   output logic pins_oe,
   output logic slot_ready,
   output logic ack,
   output logic tc_hit
);
   import fdc_dma_pkg::*;

   logic tc_active_low;

   assign pins_oe       = persona_ps2 | dor_dma_en;
   assign dma_ok        = spec_dma_en & pins_oe;
   assign slot_ready    = dir_read ? fifo_has_data : fifo_has_space;
   assign ack           = ~dack_n_s;
   assign tc_active_low = persona_ps2 ? PS2_TC_LOW : ~PS2_TC_LOW;
   assign tc_hit        = tc_decode(tc_s, tc_active_low);

   // R7: the personality that ignores the enable bit keeps the pins driven
   always_comb begin
      if (persona_ps2 && !dor_dma_en) begin
         p_ps2_drive_r7: assert (pins_oe && (dma_ok == spec_dma_en));
      end
   end
endmodule

// File: rtl/fdc_dma_seq.sv
module fdc_dma_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic single_mode,
   input  logic xfer_active,
   input  logic dma_ok,
   input  logic slot_ready,
   input  logic ack,
   input  logic tc_hit,
   input  logic dir_read,
   output logic drq,
   output logic rd_stb,
   output logic wr_stb,
   output logic done
);
   import fdc_dma_pkg::*;

   dma_st_e st, st_nx;
   logic    ack_q;
   logic    go;
   logic    first_ack;
   logic    xfer_hit;

   assign go        = xfer_active & dma_ok;
   assign first_ack = ack & ~ack_q;
   assign xfer_hit  = (st == ST_REQ) & go & first_ack;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (go && slot_ready && !ack) st_nx = ST_REQ;
         ST_REQ: begin
            if (!go)                   st_nx = ST_IDLE;
            else if (ack && tc_hit)    st_nx = ST_DONE;
            else if (ack && single_mode) st_nx = ST_HOLD;
         end
         ST_HOLD: if (!go || !ack) st_nx = ST_IDLE;
         ST_DONE: if (!xfer_active) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ack_q  <= 1'b0;
         rd_stb <= 1'b0;
         wr_stb <= 1'b0;
         done   <= 1'b0;
      end else begin
         st     <= st_nx;
         ack_q  <= ack;
         rd_stb <= xfer_hit & dir_read;
         wr_stb <= xfer_hit & ~dir_read;
         done   <= (st == ST_REQ) & go & ack & tc_hit;
      end
   end

   assign drq = (st == ST_REQ);

   p_single_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && ack && single_mode) |=> !drq);
   p_rise_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq) |-> $past(!ack));
   p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && !single_mode && go && !(ack && tc_hit)) |=> drq);
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !drq);
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !drq);
   p_stb_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));
   p_stb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> $past(drq));
   p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq) |-> $past(slot_ready));
endmodule

// File: rtl/fdc_dma_req.sv
module fdc_dma_req #(
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          PS2_TC_LOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_nburst,
   input  logic persona_ps2,
   input  logic dor_dma_en,
   input  logic spec_dma_en,
   input  logic xfer_active,
   input  logic dir_read,
   input  logic fifo_has_data,
   input  logic fifo_has_space,
   input  logic dack_n,
   input  logic tc_pin,
   output logic drq,
   output logic drq_oe,
   output logic int_oe,
   output logic fifo_rd_stb,
   output logic fifo_wr_stb,
   output logic xfer_done
);
   import fdc_dma_pkg::*;

   localparam int unsigned PIN_W = 2;
   localparam logic [PIN_W-1:0] PIN_RST = {1'b1, PS2_TC_LOW};

   generate
      if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES exceeds the supported depth");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   logic dma_ok, pins_oe, slot_ready, ack, tc_hit;

   fdc_dma_insync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dack_n, tc_pin}),
      .q     (pins_s)
   );

   fdc_dma_qual #(.PS2_TC_LOW(PS2_TC_LOW)) u_qual (
      .persona_ps2    (persona_ps2),
      .dor_dma_en     (dor_dma_en),
      .spec_dma_en    (spec_dma_en),
      .dir_read       (dir_read),
      .fifo_has_data  (fifo_has_data),
      .fifo_has_space (fifo_has_space),
      .dack_n_s       (pins_s[1]),
      .tc_s           (pins_s[0]),
      .dma_ok         (dma_ok),
      .pins_oe        (pins_oe),
      .slot_ready     (slot_ready),
      .ack            (ack),
      .tc_hit         (tc_hit)
   );

   fdc_dma_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .single_mode (mode_nburst),
      .xfer_active (xfer_active),
      .dma_ok      (dma_ok),
      .slot_ready  (slot_ready),
      .ack         (ack),
      .tc_hit      (tc_hit),
      .dir_read    (dir_read),
      .drq         (drq),
      .rd_stb      (fifo_rd_stb),
      .wr_stb      (fifo_wr_stb),
      .done        (xfer_done)
   );

   assign drq_oe = pins_oe;
   assign int_oe = pins_oe;

   p_m30_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!persona_ps2 && !dor_dma_en) |=> !drq);
   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !(drq || fifo_rd_stb || fifo_wr_stb || xfer_done));
   p_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && !mode_nburst && xfer_active && dma_ok && !tc_hit) |=> drq);
endmodule

// File: tb/fdc_dma_req_test.sv
module fdc_dma_req_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_nburst = 1'b1, persona_ps2 = 1'b1, dor_dma_en = 1'b0, spec_dma_en = 1'b0;
   logic xfer_active = 1'b0, dir_read = 1'b1, fifo_has_data = 1'b0, fifo_has_space = 1'b0;
   logic dack_n = 1'b1, tc_pin = 1'b1;
   logic drq, drq_oe, int_oe, fifo_rd_stb, fifo_wr_stb, xfer_done;
   int   n_chk = 0;
   int   n_fail = 0;

   always #10 clk = ~clk;

   fdc_dma_req uut (
      .clk(clk), .rst_n(rst_n), .mode_nburst(mode_nburst), .persona_ps2(persona_ps2),
      .dor_dma_en(dor_dma_en), .spec_dma_en(spec_dma_en), .xfer_active(xfer_active),
      .dir_read(dir_read), .fifo_has_data(fifo_has_data), .fifo_has_space(fifo_has_space),
      .dack_n(dack_n), .tc_pin(tc_pin), .drq(drq), .drq_oe(drq_oe), .int_oe(int_oe),
      .fifo_rd_stb(fifo_rd_stb), .fifo_wr_stb(fifo_wr_stb), .xfer_done(xfer_done)
   );

   function automatic logic tc_level(input logic ps2, input logic active);
      return ps2 ? ~active : active;
   endfunction

   function automatic logic exp_allowed(input logic ps2, input logic dor, input logic spec);
      return spec & (ps2 | dor);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_xfer(input logic single, input logic ps2, input logic dor,
                           input logic spec, input logic dr, input int nack);
      logic ok;
      ok = exp_allowed(ps2, dor, spec);
      mode_nburst = single; persona_ps2 = ps2; dor_dma_en = dor; spec_dma_en = spec;
      dir_read = dr; fifo_has_data = 1'b1; fifo_has_space = 1'b1;
      dack_n = 1'b1; tc_pin = tc_level(ps2, 1'b0); xfer_active = 1'b1;
      @(negedge clk);
      chk("R6/R7/R8 first request", drq, ok);
      chk("R7/R8 drq_oe", drq_oe, ps2 | dor);
      chk("R7/R8 int_oe", int_oe, ps2 | dor);
      if (!ok) begin
         dack_n = 1'b0;
         repeat (2) @(negedge clk);
         chk("R6/R8 blocked request", drq, 1'b0);
         chk("R9 no strobe when blocked", fifo_rd_stb | fifo_wr_stb, 1'b0);
      end else begin
         for (int k = 0; k < nack; k++) begin
            logic last;
            last = (k == nack - 1);
            dack_n = 1'b0; tc_pin = tc_level(ps2, last);
            @(negedge clk);
            chk("R9 read strobe", fifo_rd_stb, dr);
            chk("R9 write strobe", fifo_wr_stb, ~dr);
            chk("R1/R2/R4 drq after ack", drq, ~single & ~last);
            chk("R5 done pulse", xfer_done, last);
            dack_n = 1'b1; tc_pin = tc_level(ps2, 1'b0);
            @(negedge clk);
            chk("R9 strobe one cycle", fifo_rd_stb | fifo_wr_stb, 1'b0);
            chk("R3/R4 drq at release", drq, ~single & ~last);
            chk("R5 done one cycle", xfer_done, 1'b0);
            if (!last && single) begin
               @(negedge clk);
               chk("R3 request after gap", drq, 1'b1);
            end
         end
         repeat (2) @(negedge clk);
         chk("R5 no request after done", drq, 1'b0);
      end
      xfer_active = 1'b0; dack_n = 1'b1;
      @(negedge clk);
      chk("R6 idle after command", drq, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(negedge clk);
      chk("R10 drq in reset", drq, 1'b0);
      chk("R10 strobes in reset", fifo_rd_stb | fifo_wr_stb, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 done after reset", xfer_done, 1'b0);

      // directed corners
      run_xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3); // R1 single, R7 ps2 ignores dor
      run_xfer(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3); // R4 burst
      run_xfer(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2); // R8 blocked by dor
      run_xfer(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2); // R8 tc active high
      run_xfer(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2); // R6 no specify enable

      // R11: starved FIFO per direction
      mode_nburst = 1'b1; persona_ps2 = 1'b1; spec_dma_en = 1'b1; dack_n = 1'b1;
      tc_pin = tc_level(1'b1, 1'b0);
      dir_read = 1'b1; fifo_has_data = 1'b0; fifo_has_space = 1'b1; xfer_active = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 read waits for data", drq, 1'b0);
      fifo_has_data = 1'b1;
      @(negedge clk);
      chk("R11 read data arrives", drq, 1'b1);
      xfer_active = 1'b0;
      @(negedge clk);
      dir_read = 1'b0; fifo_has_space = 1'b0; xfer_active = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 write waits for space", drq, 1'b0);
      fifo_has_space = 1'b1;
      @(negedge clk);
      chk("R11 write space arrives", drq, 1'b1);
      xfer_active = 1'b0;
      @(negedge clk);
      chk("R6 drop on command end", drq, 1'b0);

      // constrained random
      for (int i = 0; i < 60; i++) begin
         logic spec_r;
         spec_r = ($urandom_range(0, 7) != 0);
         run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), spec_r, 1'($urandom_range(0, 1)),
                  $urandom_range(1, 4));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule